// File: doc/BRIEF.md
# Maskable Alert and Interrupt Aggregator

This block gathers single-cycle event pulses from a port controller into a sticky alert register and drives one active-low interrupt toward a host processor. The pulses report transmit outcomes, a received hard reset, a received message, power and CC status changes, and receive buffer overflow. The host reads the alert bits over a byte-wide register bus and clears them by writing ones. A matching mask register chooses which alert bits may pull the interrupt low.

Three fault sources (VCONN over-voltage, VCONN over-current and a bus protocol error) latch into a separate fault-status byte. Each fault source has its own enable mask. Any latched and enabled fault feeds one summary bit in the alert register, so interrupts come from two levels. The summary bit cannot be cleared while its cause is still latched. Positions with no function are tied off: they read zero and ignore writes.

Top module: `alert_irq_hub`

## Requirements
- R1: Register addresses are: 0 alert low byte, 1 alert high byte, 2 alert mask low, 3 alert mask high, 4 fault status, 5 fault mask. Any other address reads 0. After reset, both alert bytes and the fault status read 0x00, the alert masks read 0x7F (low) and 0x06 (high), the fault mask reads 0x03, and `irq_n_o` is 1.
- R2: An event pulse sets its alert bit at the next clock edge. Low byte positions: 6 transmit ok, 5 transmit discarded, 4 transmit failed, 3 hard reset received, 2 message received, 1 power status changed, 0 CC status changed. High byte position 2 is receive buffer overflow.
- R3: The alert and fault-status bits are write-1-to-clear. Writing a 0 to a bit leaves that bit unchanged.
- R4: If an event sets a bit in the same cycle that a bus write clears it, the bit ends up set. Other bits cleared by that same write still clear.
- R5: Unsupported positions read 0 and ignore writes. These are: alert low bit 7; alert high bits 7..3 and bit 0; the same positions in the alert masks; fault status and fault mask bits 6..2.
- R6: A mask bit of 1 means unmasked. `irq_n_o` is 0 exactly when some alert bit is set and its mask bit is 1.
- R7: Fault status latches VCONN over-voltage in bit 7, VCONN over-current in bit 1 and bus error in bit 0, one edge after the pulse.
- R8: Alert high bit 1 (fault summary) is set at the edge after a fault-status bit is latched while its fault-mask bit is 1. The over-voltage enable (fault mask bit 7) resets to 0, so a lone over-voltage fault does not raise the summary until that bit is enabled.
- R9: A write of 1 to the fault summary bit has no effect while any latched fault is enabled. Once those faults are cleared, the same write clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| tx_ok_i | input | 1 | Transmit succeeded pulse |
| tx_discard_i | input | 1 | Transmit discarded pulse |
| tx_fail_i | input | 1 | Transmit failed pulse |
| hard_rst_i | input | 1 | Hard reset received pulse |
| rx_msg_i | input | 1 | Message received pulse |
| pwr_chg_i | input | 1 | Power status changed pulse |
| cc_chg_i | input | 1 | CC status changed pulse |
| rxbuf_ovf_i | input | 1 | Receive buffer overflow pulse |
| vconn_ov_i | input | 1 | VCONN over-voltage fault pulse |
| vconn_oc_i | input | 1 | VCONN over-current fault pulse |
| bus_err_i | input | 1 | Bus protocol error fault pulse |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Two things can land on the same alert bit in one cycle: a hardware event setting it and a host write-1 clearing it. The bench raises a CC change pulse on the same clock edge as a write of 1 to that bit, then reads the bit back and expects it still set. In a second case the write also carries a 1 for the already-set power bit, and the bench expects that bit cleared while the CC bit survives. A similar conflict exists between the fault summary's continuous set and a clear request; it is judged by writing to the summary bit while a fault is latched, then again after the fault status is cleared.

// File: rtl/alert_hub_pkg.sv
// Shared constants for the alert aggregator: register addresses,
// masks of implemented bit positions, and reset values.
package alert_hub_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int ALERT_W   = 2 * BYTE_W;
    localparam int FAULT_BIT = 9;

    // Positions that exist; every other position is tied to zero.
    localparam logic [ALERT_W-1:0] ALERT_IMPL = 16'h067F;
    localparam logic [BYTE_W-1:0]  FAULT_IMPL = 8'h83;
    // The over-voltage enable starts off; the other fault enables start on.
    localparam logic [BYTE_W-1:0]  FMASK_RST  = 8'h03;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_ALERT_LO = 3'd0,
        ADDR_ALERT_HI = 3'd1,
        ADDR_MASK_LO  = 3'd2,
        ADDR_MASK_HI  = 3'd3,
        ADDR_FSTAT    = 3'd4,
        ADDR_FMASK    = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/w1c_status_reg.sv
// Sticky status bits, one flop per implemented position.
// A set pulse wins over a clear in the same cycle. A hold bit blocks the
// clear of its position. Positions not in IMPL are constant zero.
// Assumes set_i, clr_i and hold_i are synchronous to clk.
module w1c_status_reg #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] hold_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            // Latch on set; drop on an unblocked clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                       q_o[i] <= 1'b0;
                else if (set_i[i])                q_o[i] <= 1'b1;
                else if (clr_i[i] && !hold_i[i])  q_o[i] <= 1'b0;
            end
        end else begin : g_tie
            assign q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/cfg_mask_reg.sv
// Plain read/write enable bits with per-bit write enable.
// Implemented positions reset to RST; all other positions read zero.
module cfg_mask_reg #(
    parameter int           W    = 8,
    parameter logic [W-1:0] IMPL = '1,
    parameter logic [W-1:0] RST  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            // Load new value when this bit is written.
            always_ff @(posedge clk) begin
                if (!rst_n)       q_o[i] <= RST[i];
                else if (we_i[i]) q_o[i] <= wdata_i[i];
            end
        end else begin : g_tie
            assign q_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_merge.sv
// Reduces status and enable vectors to one active-low request.
// Combinational; the inputs come straight from flops.
module irq_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] enable_i,
    output logic         irq_n_o
);
    // Pull low while any enabled status bit is set.
    always_comb irq_n_o = ~|(status_i & enable_i);
endmodule

// File: rtl/alert_irq_hub.sv
// Alert and interrupt aggregator. Event pulses set sticky alert bits;
// latched faults raise one summary alert through their own enables; the
// host reads and write-1-clears over a byte bus; irq_n_o goes low for any
// unmasked alert. Assumes event pulses are synchronous to clk.
module alert_irq_hub
    import alert_hub_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic          tx_ok_i,
    input  logic          tx_discard_i,
    input  logic          tx_fail_i,
    input  logic          hard_rst_i,
    input  logic          rx_msg_i,
    input  logic          pwr_chg_i,
    input  logic          cc_chg_i,
    input  logic          rxbuf_ovf_i,
    input  logic          vconn_ov_i,
    input  logic          vconn_oc_i,
    input  logic          bus_err_i,
    output logic          irq_n_o
);
    localparam int AL_W = 2 * DW;

    logic          wr_alo, wr_ahi, wr_mlo, wr_mhi, wr_fst, wr_fmk;
    logic          fault_active;
    logic [AL_W-1:0] alert_set, alert_clr, alert_hold, alert_q;
    logic [AL_W-1:0] mask_we, mask_wd, mask_q;
    logic [DW-1:0]   fstat_set, fstat_clr, fstat_q;
    logic [DW-1:0]   fmask_we, fmask_q;

    // Decode the write strobe per register.
    always_comb begin
        wr_alo = bus_wr_i && (bus_addr_i == AW'(ADDR_ALERT_LO));
        wr_ahi = bus_wr_i && (bus_addr_i == AW'(ADDR_ALERT_HI));
        wr_mlo = bus_wr_i && (bus_addr_i == AW'(ADDR_MASK_LO));
        wr_mhi = bus_wr_i && (bus_addr_i == AW'(ADDR_MASK_HI));
        wr_fst = bus_wr_i && (bus_addr_i == AW'(ADDR_FSTAT));
        wr_fmk = bus_wr_i && (bus_addr_i == AW'(ADDR_FMASK));
    end

    // Second level: any latched fault whose enable is on.
    always_comb fault_active = |(fstat_q & fmask_q);

    // Place event pulses at their alert positions and form clear and hold.
    always_comb begin
        alert_set = '0;
        alert_set[0]  = cc_chg_i;
        alert_set[1]  = pwr_chg_i;
        alert_set[2]  = rx_msg_i;
        alert_set[3]  = hard_rst_i;
        alert_set[4]  = tx_fail_i;
        alert_set[5]  = tx_discard_i;
        alert_set[6]  = tx_ok_i;
        alert_set[FAULT_BIT] = fault_active;
        alert_set[DW+2] = rxbuf_ovf_i;
        alert_clr  = {(wr_ahi ? bus_wdata_i : '0), (wr_alo ? bus_wdata_i : '0)};
        alert_hold = '0;
        alert_hold[FAULT_BIT] = fault_active;
    end

    // Place fault pulses at their fault-status positions.
    always_comb begin
        fstat_set    = '0;
        fstat_set[7] = vconn_ov_i;
        fstat_set[1] = vconn_oc_i;
        fstat_set[0] = bus_err_i;
        fstat_clr    = wr_fst ? bus_wdata_i : '0;
    end

    // Byte-lane write enables for the mask registers.
    always_comb begin
        mask_we  = {{DW{wr_mhi}}, {DW{wr_mlo}}};
        mask_wd  = {bus_wdata_i, bus_wdata_i};
        fmask_we = {DW{wr_fmk}};
    end

    w1c_status_reg #(.W(AL_W), .IMPL(ALERT_IMPL)) u_alert (
        .clk(clk), .rst_n(rst_n), .set_i(alert_set), .clr_i(alert_clr),
        .hold_i(alert_hold), .q_o(alert_q)
    );

    w1c_status_reg #(.W(DW), .IMPL(FAULT_IMPL)) u_fstat (
        .clk(clk), .rst_n(rst_n), .set_i(fstat_set), .clr_i(fstat_clr),
        .hold_i('0), .q_o(fstat_q)
    );

    cfg_mask_reg #(.W(AL_W), .IMPL(ALERT_IMPL), .RST(ALERT_IMPL)) u_amask (
        .clk(clk), .rst_n(rst_n), .we_i(mask_we), .wdata_i(mask_wd), .q_o(mask_q)
    );

    cfg_mask_reg #(.W(DW), .IMPL(FAULT_IMPL), .RST(FMASK_RST)) u_fmask (
        .clk(clk), .rst_n(rst_n), .we_i(fmask_we), .wdata_i(bus_wdata_i), .q_o(fmask_q)
    );

    irq_merge #(.W(AL_W)) u_irq (
        .status_i(alert_q), .enable_i(mask_q), .irq_n_o(irq_n_o)
    );

    // Return the addressed register; unmapped addresses read zero.
    always_comb begin
        case (bus_addr_i)
            AW'(ADDR_ALERT_LO): bus_rdata_o = alert_q[DW-1:0];
            AW'(ADDR_ALERT_HI): bus_rdata_o = alert_q[AL_W-1:DW];
            AW'(ADDR_MASK_LO):  bus_rdata_o = mask_q[DW-1:0];
            AW'(ADDR_MASK_HI):  bus_rdata_o = mask_q[AL_W-1:DW];
            AW'(ADDR_FSTAT):    bus_rdata_o = fstat_q;
            AW'(ADDR_FMASK):    bus_rdata_o = fmask_q;
            default:            bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/alert_irq_hub_chk.sv
// Property checker for alert_irq_hub, attached by the bind below.
// Watches ports and the register outputs of the submodules.
module alert_irq_hub_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr_i,
    input logic [2:0]  bus_addr_i,
    input logic [7:0]  bus_wdata_i,
    input logic [7:0]  bus_rdata_o,
    input logic        cc_chg_i,
    input logic        vconn_oc_i,
    input logic        irq_n_o,
    input logic [15:0] alert_q,
    input logic [7:0]  fstat_q,
    input logic [7:0]  fmask_q
);
    a_r2_cc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cc_chg_i |=> alert_q[0]);

    a_r3_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 3'd0 && bus_wdata_i[0] && !cc_chg_i) |=> !alert_q[0]);

    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 3'd0 && !bus_wdata_i[0] && alert_q[0]) |=> alert_q[0]);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_chg_i && bus_wr_i && bus_addr_i == 3'd0 && bus_wdata_i[0]) |=> alert_q[0]);

    a_r5_unsup_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == 3'd1) |-> (bus_rdata_o[7:3] == 5'd0 && !bus_rdata_o[0]));

    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (alert_q != 16'd0));

    a_r7_oc_latch: assert property (@(posedge clk) disable iff (!rst_n)
        vconn_oc_i |=> fstat_q[1]);

    a_r9_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((fstat_q & fmask_q) != 8'd0) |=> alert_q[9]);
endmodule

bind alert_irq_hub alert_irq_hub_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .cc_chg_i(cc_chg_i),
    .vconn_oc_i(vconn_oc_i), .irq_n_o(irq_n_o), .alert_q(alert_q),
    .fstat_q(fstat_q), .fmask_q(fmask_q)
);

// File: tb/alert_irq_hub_tb_top.sv
// Directed bench: one task per scenario, inputs driven and outputs
// sampled on the falling edge.
module alert_irq_hub_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [10:0] ev = 11'd0;
    logic       irq_n;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    // ev order: tx_ok, tx_discard, tx_fail, hard_rst, rx_msg, pwr_chg,
    //           cc_chg, rxbuf_ovf, vconn_ov, vconn_oc, bus_err
    alert_irq_hub dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .tx_ok_i(ev[10]), .tx_discard_i(ev[9]), .tx_fail_i(ev[8]),
        .hard_rst_i(ev[7]), .rx_msg_i(ev[6]), .pwr_chg_i(ev[5]),
        .cc_chg_i(ev[4]), .rxbuf_ovf_i(ev[3]), .vconn_ov_i(ev[2]),
        .vconn_oc_i(ev[1]), .bus_err_i(ev[0]), .irq_n_o(irq_n)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [10:0] v);
        ev = v;
        step();
        ev = '0;
    endtask

    task automatic t_reset();
        rd_chk("R1 alert lo", 3'd0, 8'h00);
        rd_chk("R1 alert hi", 3'd1, 8'h00);
        rd_chk("R1 mask lo", 3'd2, 8'h7F);
        rd_chk("R1 mask hi", 3'd3, 8'h06);
        rd_chk("R1 fault stat", 3'd4, 8'h00);
        rd_chk("R1 fault mask", 3'd5, 8'h03);
        rd_chk("R1 unmapped", 3'd7, 8'h00);
        chk("R1 irq idle", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_events();
        for (int i = 0; i < 7; i++) begin
            pulse(11'(1) << (4 + i));
            rd_chk("R2 low event", 3'd0, 8'(1) << i);
            chk("R6 irq on event", {7'd0, irq_n}, 8'h00);
            wr(3'd0, 8'hFF);
        end
        pulse(11'h008);
        rd_chk("R2 overflow", 3'd1, 8'h04);
        wr(3'd1, 8'h04);
        rd_chk("R3 overflow cleared", 3'd1, 8'h00);
        chk("R6 irq released", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_w1c();
        pulse(11'h030);
        rd_chk("R3 two set", 3'd0, 8'h03);
        wr(3'd0, 8'h01);
        rd_chk("R3 clear one", 3'd0, 8'h02);
        wr(3'd0, 8'h00);
        rd_chk("R3 zero keeps", 3'd0, 8'h02);
        wr(3'd0, 8'h02);
        rd_chk("R3 clear rest", 3'd0, 8'h00);
    endtask

    task automatic t_collide();
        pulse(11'h010);
        ev = 11'h010;
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h01;
        step();
        ev = '0; bus_wr = 1'b0;
        rd_chk("R4 set beats clear", 3'd0, 8'h01);
        pulse(11'h020);
        ev = 11'h010;
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h03;
        step();
        ev = '0; bus_wr = 1'b0;
        rd_chk("R4 neighbour clears", 3'd0, 8'h01);
        wr(3'd0, 8'h01);
    endtask

    task automatic t_unsup();
        wr(3'd1, 8'hFF);
        rd_chk("R5 alert hi", 3'd1, 8'h00);
        wr(3'd0, 8'h80);
        rd_chk("R5 alert lo b7", 3'd0, 8'h00);
        wr(3'd3, 8'hFF);
        rd_chk("R5 mask hi", 3'd3, 8'h06);
        wr(3'd2, 8'hFF);
        rd_chk("R5 mask lo", 3'd2, 8'h7F);
        wr(3'd5, 8'hFF);
        rd_chk("R5 fault mask", 3'd5, 8'h83);
        wr(3'd5, 8'h03);
        wr(3'd4, 8'hFF);
        rd_chk("R5 fault stat", 3'd4, 8'h00);
    endtask

    task automatic t_mask();
        pulse(11'h010);
        chk("R6 unmasked low", {7'd0, irq_n}, 8'h00);
        wr(3'd2, 8'h7E);
        chk("R6 masked high", {7'd0, irq_n}, 8'h01);
        rd_chk("R6 bit kept", 3'd0, 8'h01);
        wr(3'd2, 8'h7F);
        chk("R6 unmask again", {7'd0, irq_n}, 8'h00);
        wr(3'd0, 8'h01);
        chk("R6 clear idle", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_fault();
        pulse(11'h002);
        rd_chk("R7 oc latched", 3'd4, 8'h02);
        rd_chk("R8 summary lag", 3'd1, 8'h00);
        step();
        rd_chk("R8 summary set", 3'd1, 8'h02);
        chk("R8 irq from fault", {7'd0, irq_n}, 8'h00);
        wr(3'd1, 8'h02);
        rd_chk("R9 summary held", 3'd1, 8'h02);
        wr(3'd4, 8'h02);
        rd_chk("R7 oc cleared", 3'd4, 8'h00);
        wr(3'd1, 8'h02);
        rd_chk("R9 summary cleared", 3'd1, 8'h00);
        chk("R9 irq idle", {7'd0, irq_n}, 8'h01);
        pulse(11'h004);
        step();
        rd_chk("R7 ov latched", 3'd4, 8'h80);
        rd_chk("R8 ov disabled", 3'd1, 8'h00);
        chk("R8 irq stays high", {7'd0, irq_n}, 8'h01);
        wr(3'd5, 8'h83);
        step();
        rd_chk("R8 ov enabled", 3'd1, 8'h02);
        wr(3'd4, 8'h80);
        wr(3'd1, 8'h02);
        rd_chk("R9 ov summary cleared", 3'd1, 8'h00);
        wr(3'd5, 8'h03);
        pulse(11'h001);
        rd_chk("R7 bus err latched", 3'd4, 8'h01);
        wr(3'd4, 8'h00);
        rd_chk("R3 fault zero keeps", 3'd4, 8'h01);
        wr(3'd4, 8'h01);
        step();
        wr(3'd1, 8'h02);
        rd_chk("R3 fault cleared", 3'd4, 8'h00);
        rd_chk("R9 final summary", 3'd1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_w1c();
        t_collide();
        t_unsup();
        t_mask();
        t_fault();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule